// File: doc/BRIEF.md
# Source Group-Bit Receive Filter

This block sits in the receive path of a ring MAC. When the address parser has the destination and source addresses of a frame, it pulses a strobe. The filter then gives a one-cycle verdict: whether the frame goes to the host, and whether the source address is the station's own address. The verdict is built from three things. The first is a destination match against the station's long address. The second is a copy mode that can accept every frame. The third is an optional rule that discards frames whose source address has its individual/group bit set.

The discard rule is bypassed in two cases: when the copy mode accepts everything, and when the frame is a next-station-addressing frame. Destination matching uses every bit of the own address, including its group bit. Source matching masks the group bit on both sides, so that bit never causes a mismatch. Frames with 16-bit addresses use only the low 16 bits of each address, and their group bit is bit 15. A two-flop synchronizer releases the reset on a clock edge.

Top module: `sgf_rx_filter`

## Requirements
- R1: While reset is held and right after it, `copy_valid`, `copy_frame` and `sa_own` are all 0.
- R2: `copy_valid` is 1 in exactly the cycle after a cycle with `addr_done` high, and 0 otherwise. The verdict registered on that edge is what `copy_frame` and `sa_own` show.
- R3: The source group bit is `sa[47]` when `addr_long`=1 and `sa[15]` when `addr_long`=0. For 16-bit frames, bits 47:16 of every address are ignored.
- R4: With `flush_en`=0, a source group bit of 1 does not stop a frame from being copied.
- R5: With `flush_en`=1, `copy_mode` 2'b00 or 2'b01, and `nsa_frame`=0, a frame whose source group bit is 1 gives `copy_frame`=0.
- R6: With `copy_mode` 2'b10 or 2'b11, every frame gives `copy_frame`=1, whatever the values of `flush_en` and the destination.
- R7: A frame with `nsa_frame`=1 is never discarded by the flush rule. It still needs a destination match in modes 2'b00 and 2'b01.
- R8: In modes 2'b00 and 2'b01, `copy_frame`=1 only when the destination matches. For long frames the match compares all 48 bits, bit 47 included. For short frames it compares `da[15:0]` with `own_addr[15:0]`.
- R9: `sa_own`=1 when the source equals `own_addr` with the group bit left out of both: bits 46:0 for long frames, bits 14:0 for short frames.
- R10: In cycles where `addr_done` is low, `copy_frame` and `sa_own` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_done | input | 1 | Address fields complete; capture a verdict |
| addr_long | input | 1 | 1 = 48-bit addresses, 0 = 16-bit addresses |
| copy_mode | input | 2 | 00/01 copy on destination match; 10/11 copy all frames |
| flush_en | input | 1 | Discard frames whose source group bit is set |
| nsa_frame | input | 1 | Frame is a next-station-addressing frame |
| da | input | 48 | Destination address |
| sa | input | 48 | Source address |
| own_addr | input | 48 | Station's own long address |
| copy_valid | output | 1 | Verdict valid strobe |
| copy_frame | output | 1 | Copy the frame to the host |
| sa_own | output | 1 | Source matches own address, group bit masked |

## Verification
Several rules are checked by assertions on every clock: the valid strobe follows the address strobe by one cycle, the outputs hold between strobes, copy-all modes always copy, the flush rule rejects a non-exempt frame with the source group bit set, and a destination miss blocks the copy in the matching modes. The bench scenarios are needed for the rest. These are the masked source comparison, the choice of group bit between 16-bit and 48-bit frames, the destination compare including bit 47, the exemption for next-station-addressing frames, and the reset values.

// File: rtl/sgf_pkg.sv
package sgf_pkg;
  typedef enum logic [1:0] {
    CM_MATCH_A = 2'b00,
    CM_MATCH_B = 2'b01,
    CM_ALL_A   = 2'b10,
    CM_ALL_B   = 2'b11
  } copy_mode_e;

  typedef struct packed {
    logic copy;
    logic sa_own;
  } verdict_t;

  function automatic logic mode_copies_all(input copy_mode_e m);
    return (m == CM_ALL_A) || (m == CM_ALL_B);
  endfunction
endpackage

// File: rtl/sgf_rst_sync.sv
module sgf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = chain[STAGES-1];
endmodule

// File: rtl/sgf_addr_match.sv
module sgf_addr_match #(
  parameter int LONG_W     = 48,
  parameter int SHORT_W    = 16,
  parameter bit SKIP_GROUP = 1'b0
) (
  input  logic [LONG_W-1:0] addr,
  input  logic [LONG_W-1:0] own,
  input  logic              is_long,
  output logic              hit
);
  localparam int LG  = LONG_W - 1;
  localparam int SG  = SHORT_W - 1;
  localparam int PAD = LONG_W - SHORT_W;

  logic [LONG_W-1:0] long_mask;
  logic [LONG_W-1:0] short_mask;
  logic [LONG_W-1:0] diff;

  generate
    if (SKIP_GROUP) begin : g_skip_group
      assign long_mask  = {1'b0, {LG{1'b1}}};
      assign short_mask = {{(PAD + 1){1'b0}}, {SG{1'b1}}};
    end else begin : g_full
      assign long_mask  = {LONG_W{1'b1}};
      assign short_mask = {{PAD{1'b0}}, {SHORT_W{1'b1}}};
    end
  endgenerate

  always_comb begin
    diff = (addr ^ own) & (is_long ? long_mask : short_mask);
    hit  = ~|diff;
  end
endmodule

// File: rtl/sgf_flush_gate.sv
module sgf_flush_gate
  import sgf_pkg::*;
#(
  parameter int LONG_W  = 48,
  parameter int SHORT_W = 16
) (
  input  logic [LONG_W-1:0] sa,
  input  logic              is_long,
  input  logic              flush_en,
  input  logic              nsa_frame,
  input  copy_mode_e        mode,
  output logic              sa_group,
  output logic              reject
);
  always_comb begin
    sa_group = is_long ? sa[LONG_W-1] : sa[SHORT_W-1];
    reject   = flush_en & sa_group & ~nsa_frame & ~mode_copies_all(mode);
  end
endmodule

// File: rtl/sgf_rx_filter.sv
module sgf_rx_filter
  import sgf_pkg::*;
#(
  parameter int LONG_W  = 48,
  parameter int SHORT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_done,
  input  logic              addr_long,
  input  logic [1:0]        copy_mode,
  input  logic              flush_en,
  input  logic              nsa_frame,
  input  logic [LONG_W-1:0] da,
  input  logic [LONG_W-1:0] sa,
  input  logic [LONG_W-1:0] own_addr,
  output logic              copy_valid,
  output logic              copy_frame,
  output logic              sa_own
);
  localparam int LGB = LONG_W - 1;
  localparam int SGB = SHORT_W - 1;

  logic       rst_q_n;
  copy_mode_e mode;
  logic       da_hit;
  logic       sa_hit;
  logic       sa_group;
  logic       reject;
  verdict_t   verdict_d, verdict_q;
  logic       valid_d, valid_q;

  assign mode = copy_mode_e'(copy_mode);

  sgf_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  sgf_addr_match #(.LONG_W(LONG_W), .SHORT_W(SHORT_W), .SKIP_GROUP(1'b0)) u_da_cmp (
    .addr    (da),
    .own     (own_addr),
    .is_long (addr_long),
    .hit     (da_hit)
  );

  sgf_addr_match #(.LONG_W(LONG_W), .SHORT_W(SHORT_W), .SKIP_GROUP(1'b1)) u_sa_cmp (
    .addr    (sa),
    .own     (own_addr),
    .is_long (addr_long),
    .hit     (sa_hit)
  );

  sgf_flush_gate #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_gate (
    .sa        (sa),
    .is_long   (addr_long),
    .flush_en  (flush_en),
    .nsa_frame (nsa_frame),
    .mode      (mode),
    .sa_group  (sa_group),
    .reject    (reject)
  );

  // next-state logic
  always_comb begin
    valid_d   = addr_done;
    verdict_d = verdict_q;
    if (addr_done) begin
      verdict_d.copy   = mode_copies_all(mode) | (da_hit & ~reject);
      verdict_d.sa_own = sa_hit;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      valid_q   <= 1'b0;
      verdict_q <= '0;
    end else begin
      valid_q <= valid_d;
      if (addr_done) verdict_q <= verdict_d;
    end
  end

  assign copy_valid = valid_q;
  assign copy_frame = verdict_q.copy;
  assign sa_own     = verdict_q.sa_own;

  p_valid_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    addr_done |=> copy_valid);

  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !addr_done |=> !copy_valid);

  p_hold_between_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !addr_done |=> ($stable(copy_frame) && $stable(sa_own)));

  p_flush_drops_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (addr_done && flush_en && !copy_mode[1] && !nsa_frame &&
     (addr_long ? sa[LGB] : sa[SGB])) |=> !copy_frame);

  p_copy_all_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (addr_done && copy_mode[1]) |=> copy_frame);

  p_da_required_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (addr_done && !copy_mode[1] && !da_hit) |=> !copy_frame);
endmodule

// File: tb/sgf_rx_filter_test.sv
module sgf_rx_filter_test;
  localparam logic [47:0] OWN   = 48'h8A5C_3E91_07D2;
  localparam logic [47:0] OWNG0 = 48'h0A5C_3E91_07D2;
  localparam logic [47:0] OTHG1 = 48'hC000_0000_0001;
  localparam logic [47:0] OTHG0 = 48'h1234_5678_9ABC;
  localparam logic [47:0] SDA   = 48'hFFFF_FFFF_07D2;
  localparam logic [47:0] SSA1  = 48'h0000_0000_87D2;
  localparam logic [47:0] SSA0  = 48'h8000_0000_07D2;
  localparam int NV = 12;

  // {long, mode[1:0], flush, nsa, da[47:0], sa[47:0], exp_copy, exp_own}
  localparam logic [102:0] TBL [NV] = '{
    {1'b1, 2'b00, 1'b0, 1'b0, OWN,   OTHG0, 1'b1, 1'b0}, // R8 long DA hit
    {1'b1, 2'b00, 1'b1, 1'b0, OWN,   OWN,   1'b0, 1'b1}, // R5 flush drop, R9 group ignored
    {1'b1, 2'b00, 1'b0, 1'b0, OWN,   OWN,   1'b1, 1'b1}, // R4 flush off
    {1'b1, 2'b01, 1'b1, 1'b0, OWN,   OWNG0, 1'b1, 1'b1}, // R5 group clear passes, R9
    {1'b1, 2'b00, 1'b0, 1'b0, OWNG0, OTHG0, 1'b0, 1'b0}, // R8 bit 47 compared
    {1'b1, 2'b10, 1'b1, 1'b0, OWNG0, OTHG1, 1'b1, 1'b0}, // R6 mode 10
    {1'b1, 2'b11, 1'b1, 1'b0, OTHG0, OWN,   1'b1, 1'b1}, // R6 mode 11
    {1'b1, 2'b00, 1'b1, 1'b1, OWN,   OTHG1, 1'b1, 1'b0}, // R7 NSA exempt
    {1'b1, 2'b01, 1'b1, 1'b1, OTHG0, OTHG1, 1'b0, 1'b0}, // R7 NSA needs DA
    {1'b0, 2'b00, 1'b1, 1'b0, SDA,   SSA1,  1'b0, 1'b1}, // R3 short group bit 15
    {1'b0, 2'b00, 1'b1, 1'b0, SDA,   SSA0,  1'b1, 1'b1}, // R3 bit 47 ignored in short
    {1'b0, 2'b01, 1'b0, 1'b0, SSA1,  OTHG0, 1'b0, 1'b0}  // R8 short DA bit 15
  };

  logic clk, rst_n, addr_done, addr_long, flush_en, nsa_frame;
  logic [1:0] copy_mode;
  logic [47:0] da, sa, own_addr;
  logic copy_valid, copy_frame, sa_own;
  int n_chk, n_bad;
  bit finished;

  sgf_rx_filter uut (
    .clk(clk), .rst_n(rst_n), .addr_done(addr_done), .addr_long(addr_long),
    .copy_mode(copy_mode), .flush_en(flush_en), .nsa_frame(nsa_frame),
    .da(da), .sa(sa), .own_addr(own_addr),
    .copy_valid(copy_valid), .copy_frame(copy_frame), .sa_own(sa_own)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic apply(input logic [102:0] v);
    @(negedge clk);
    addr_long = v[102]; copy_mode = v[101:100]; flush_en = v[99];
    nsa_frame = v[98];  da = v[97:50]; sa = v[49:2];
    addr_done = 1'b1;
    @(negedge clk);
    addr_done = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; finished = 1'b0;
    rst_n = 1'b0; addr_done = 1'b0; addr_long = 1'b1; copy_mode = 2'b10;
    flush_en = 1'b0; nsa_frame = 1'b0; da = OWN; sa = OWN; own_addr = OWN;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", copy_valid, 1'b0);
    chk("R1 copy in reset", copy_frame, 1'b0);
    chk("R1 sa_own in reset", sa_own, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 valid after release", copy_valid, 1'b0);
    chk("R1 copy after release", copy_frame, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      chk($sformatf("R2 valid vec %0d", i), copy_valid, 1'b1);
      chk($sformatf("R3-R8 copy vec %0d", i), copy_frame, TBL[i][1]);
      chk($sformatf("R9 sa_own vec %0d", i), sa_own, TBL[i][0]);
    end

    // R10: inputs that would flip the verdict, no strobe
    apply({1'b1, 2'b00, 1'b0, 1'b0, OWN, OWN, 1'b1, 1'b1});
    addr_long = 1'b1; copy_mode = 2'b00; flush_en = 1'b1; da = OTHG0; sa = OTHG1;
    @(negedge clk);
    chk("R2 valid drops", copy_valid, 1'b0);
    chk("R10 copy held", copy_frame, 1'b1);
    chk("R10 sa_own held", sa_own, 1'b1);
    repeat (4) @(negedge clk);
    chk("R10 copy held later", copy_frame, 1'b1);
    chk("R2 valid stays low", copy_valid, 1'b0);

    // back-to-back strobes
    @(negedge clk);
    addr_done = 1'b1; copy_mode = 2'b00; flush_en = 1'b0; da = OWN; sa = OTHG0;
    @(negedge clk);
    chk("R2 b2b first valid", copy_valid, 1'b1);
    chk("R8 b2b first copy", copy_frame, 1'b1);
    da = OTHG0;
    @(negedge clk);
    addr_done = 1'b0;
    chk("R2 b2b second valid", copy_valid, 1'b1);
    chk("R8 b2b second copy", copy_frame, 1'b0);

    // R1: reset during operation
    apply({1'b1, 2'b11, 1'b0, 1'b0, OWN, OWN, 1'b1, 1'b1});
    rst_n = 1'b0;
    #1;
    chk("R1 mid reset copy", copy_frame, 1'b0);
    chk("R1 mid reset sa_own", sa_own, 1'b0);
    chk("R1 mid reset valid", copy_valid, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule